// File: doc/BRIEF.md
# Framed Serial Switch Loader

This block takes a stream of ASCII characters, one per valid strobe, from a byte receiver. It builds a switch configuration from that stream and loads it into a chain of eight serially connected 8-bit switch registers. A frame opens with `<` and closes with `>`. Between the two markers the frame holds eight decimal numbers separated by commas. Each number sets one switch register. Characters outside a frame are dropped.

When a frame closes with exactly eight legal values, the block lowers the active-low select and sends all 64 bits on a serial clock and data pair. Data goes out most significant bit first. Once the last bit is out, the select rises again, and the whole chain updates its outputs at once on that rising edge. The first value of the frame is sent first, so after the shift it sits in the register furthest down the chain. A malformed frame raises an error flag, and nothing is sent.

Top module: `serial_switch_loader`

## Requirements
- R1: Characters received while no frame is open are discarded. They start no transfer and do not set the error flag.
- R2: Each field is a string of decimal digits (0x30..0x39) and fields are separated by a comma (0x2C). The eight values are sent as 64 bits, most significant bit first, with the first field first. A chain that shifts in on each rising clock then holds field 1 in its top byte and field 8 in its bottom byte.
- R3: `cs_n` stays low for the entire transfer. Exactly 64 rising edges of `sck` occur while it is low, and `sck` stays low whenever `cs_n` is high.
- R4: Each half period of `sck` lasts CLK_DIV clocks, so a transfer keeps `busy` high for 128*CLK_DIV cycles. `sdo` changes only while `sck` is low and is steady while `sck` is high.
- R5: A field value above 255 sets `frame_err` when the frame closes, and no transfer starts. The value 255 is legal.
- R6: A frame holding fewer or more than eight fields sets `frame_err`, and no transfer starts.
- R7: An empty field, or any character other than a digit, a comma or a marker inside a frame, sets `frame_err`, and no transfer starts.
- R8: A `<` received inside an open frame throws away the fields collected so far and starts parsing again.
- R9: `busy` is high from the cycle after a good `>` until `cs_n` rises. Characters presented while `busy` is high are ignored.
- R10: After reset, `cs_n`=1, `sck`=0, `busy`=0 and `frame_err`=0.
- R11: `frame_err` stays set until the next `<` arrives, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Character strobe, one cycle per character |
| rx_byte | input | 8 | ASCII character |
| sck | output | 1 | Serial shift clock, idles low |
| sdo | output | 1 | Serial data to the switch chain |
| cs_n | output | 1 | Active-low select; its rising edge updates the chain |
| busy | output | 1 | Transfer in progress |
| frame_err | output | 1 | Last frame was malformed |

## Verification
Two good frames with different values are sent, one of them containing the limits 0 and 255. Together they show that the fields are placed in the right order and that each byte goes out most significant bit first, rather than only showing that some bits toggled. Several bad frames then each target one rule: an out-of-range value, too few fields, too many fields, a letter, and an empty field. Each of these must raise the error flag, and none may produce a select pulse. A frame restarted by a second `<`, a complete frame sent while a transfer is running, and stray text before any frame show whether the block discards input in the right places.

// File: rtl/serial_switch_loader.sv
module serial_switch_loader #(
  parameter int NUM_BYTES = 8,
  parameter int CLK_DIV   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       sck,
  output logic       sdo,
  output logic       cs_n,
  output logic       busy,
  output logic       frame_err
);
  localparam int TOTAL_BITS = NUM_BYTES * 8;
  localparam int BW = $clog2(TOTAL_BITS);
  localparam int CW = $clog2(NUM_BYTES + 1);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic                  in_frame, have_digit, bad;
  logic [7:0]            acc;
  logic [CW-1:0]         cnt;
  logic [TOTAL_BITS-1:0] frame_q, sr;
  logic [BW-1:0]         bitcnt;
  logic [DW-1:0]         div;

  wire        take     = rx_valid && !busy;
  wire        is_digit = rx_byte >= 8'h30 && rx_byte <= 8'h39;
  wire [11:0] acc_next = {4'd0, acc} * 12'd10 + {8'd0, rx_byte[3:0]};
  wire        last_ok  = have_digit && !bad && cnt == CW'(NUM_BYTES - 1);

  assign sdo  = sr[TOTAL_BITS-1];
  assign cs_n = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0; have_digit <= 1'b0; bad <= 1'b0; acc <= '0; cnt <= '0;
      frame_q <= '0; sr <= '0; bitcnt <= '0; div <= '0;
      sck <= 1'b0; busy <= 1'b0; frame_err <= 1'b0;
    end else begin
      if (busy) begin
        if (div == DW'(CLK_DIV - 1)) begin
          div <= '0;
          if (!sck) sck <= 1'b1;
          else begin
            sck <= 1'b0;
            if (bitcnt == BW'(TOTAL_BITS - 1)) busy <= 1'b0;
            else begin
              sr     <= sr << 1;
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end else div <= div + 1'b1;
      end
      if (take) begin
        if (rx_byte == 8'h3C) begin
          in_frame <= 1'b1; have_digit <= 1'b0; bad <= 1'b0;
          acc <= '0; cnt <= '0; frame_err <= 1'b0;
        end else if (in_frame) begin
          if (is_digit) begin
            acc <= acc_next[7:0];
            have_digit <= 1'b1;
            if (acc_next > 12'd255) bad <= 1'b1;
          end else if (rx_byte == 8'h2C) begin
            if (!have_digit || cnt >= CW'(NUM_BYTES - 1)) bad <= 1'b1;
            frame_q    <= {frame_q[TOTAL_BITS-9:0], acc};
            cnt        <= cnt + 1'b1;
            acc        <= '0;
            have_digit <= 1'b0;
          end else if (rx_byte == 8'h3E) begin
            in_frame <= 1'b0;
            if (last_ok) begin
              sr <= {frame_q[TOTAL_BITS-9:0], acc};
              busy <= 1'b1; bitcnt <= '0; div <= '0; sck <= 1'b0;
            end else frame_err <= 1'b1;
          end else bad <= 1'b1;
        end
      end
    end
  end

  a_r3_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  a_r4_sdo_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(sdo));
  a_r5_err_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !busy);
  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rx_valid) |=> ($stable(cnt) && $stable(in_frame) && $stable(frame_err)));
endmodule

// File: tb/serial_switch_loader_bench.sv
module serial_switch_loader_bench;
  localparam int DIV = 4;
  logic clk = 1'b0, rst_n = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic sck, sdo, cs_n, busy, frame_err;
  int total = 0, bad = 0, xfers = 0, expected_xfers = 0;
  logic armed = 1'b0;
  logic [63:0] cap = '0;
  int rises = 0, busy_cycles = 0;
  logic [63:0] sb[$];

  serial_switch_loader #(.NUM_BYTES(8), .CLK_DIV(DIV)) u_serial_switch_loader (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .sck(sck), .sdo(sdo), .cs_n(cs_n), .busy(busy), .frame_err(frame_err));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_byte = s[i];
      @(negedge clk); rx_valid = 1'b0;
    end
  endtask

  task automatic expect_frame(input logic [63:0] w);
    sb.push_back(w);
    expected_xfers++;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  always @(posedge sck) if (armed && !cs_n) begin cap <= {cap[62:0], sdo}; rises++; end
  always @(negedge clk) if (armed && busy) busy_cycles++;

  always @(posedge cs_n) if (armed) begin
    #1;
    xfers++;
    if (sb.size() == 0) chk("R1 unexpected transfer", 64'd1, 64'd0);
    else begin
      logic [63:0] w;
      w = sb.pop_front();
      chk("R2 chain contents", cap, w);
      chk("R3 sck rising edges", 64'(rises), 64'd64);
      chk("R4 busy duration", 64'(busy_cycles), 64'(128 * DIV));
    end
    rises = 0; busy_cycles = 0;
  end

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; armed = 1'b1;
    @(negedge clk);
    chk("R10 cs_n", 64'(cs_n), 64'd1);
    chk("R10 sck", 64'(sck), 64'd0);
    chk("R10 busy", 64'(busy), 64'd0);
    chk("R10 frame_err", 64'(frame_err), 64'd0);

    send_str("abc,12>9,9");
    wait_idle();
    chk("R1 no error outside frame", 64'(frame_err), 64'd0);

    expect_frame(64'h0102030405060708);
    send_str("<1,2,3,4,5,6,7,8>");
    wait_idle();
    chk("R2 no error good frame", 64'(frame_err), 64'd0);

    expect_frame(64'hFF0080_11AA55_09C8);
    send_str("<255,0,128,17,170,85,9,200>");
    wait_idle();

    send_str("<256,1,2,3,4,5,6,7>");
    wait_idle();
    chk("R5 overrange error", 64'(frame_err), 64'd1);

    send_str("<1,2,3>");
    wait_idle();
    chk("R6 short frame error", 64'(frame_err), 64'd1);
    send_str("<1,2,3,4,5,6,7,8,9>");
    wait_idle();
    chk("R6 long frame error", 64'(frame_err), 64'd1);

    send_str("<1,a,3,4,5,6,7,8>");
    wait_idle();
    chk("R7 illegal char error", 64'(frame_err), 64'd1);
    send_str("<1,,3,4,5,6,7,8>");
    wait_idle();
    chk("R7 empty field error", 64'(frame_err), 64'd1);

    send_str("<");
    chk("R11 error cleared by marker", 64'(frame_err), 64'd0);
    expect_frame(64'h0A141E28323C4650);
    send_str("10,20,30,40,50,60,70,80>");
    wait_idle();

    expect_frame(64'h0B16212C37424D58);
    send_str("<9,9,9<11,22,33,44,55,66,77,88>");
    wait_idle();
    chk("R8 restart no error", 64'(frame_err), 64'd0);

    expect_frame(64'h8040201008040201);
    send_str("<128,64,32,16,8,4,2,1>");
    chk("R9 busy during shift", 64'(busy), 64'd1);
    chk("R3 cs_n low during shift", 64'(cs_n), 64'd0);
    send_str("<1,1,1,1,1,1,1,1>");
    wait_idle();
    repeat (700) @(negedge clk);
    chk("R9 input ignored while busy", 64'(xfers), 64'(expected_xfers));
    chk("R9 no error from ignored input", 64'(frame_err), 64'd0);
    chk("R2 scoreboard drained", 64'(sb.size()), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule